// File: doc/BRIEF.md
# Stereo Pair Mute and Lock Controller

This block sits on the output side of four stereo sample-rate converters and decides, for each pair, whether its audio reaches the rest of the chip at full level, at silence, or somewhere on a ramp between the two. Pair n carries channels 2n and 2n+1. Software sees two 16-bit registers on a small read/write bus. One holds the per-pair mute requests together with the read-only per-pair lock flags. The other holds a single ramp-disable bit.

Each converter reports two plain signals: a clock-enable indication and a lock-achieved indication. A pair's lock flag reads 0 after reset. It rises to 1 once the pair's clock is enabled. It falls to 0 for good the first time lock is reached. While a pair has not reached lock, its output is forced silent. Otherwise the mute request bit decides. Fades run linearly across 1024 accepted samples. Setting the ramp-disable bit makes every change immediate and makes the pair ignore the software mute bits, so that only the lock state mutes it.

Audio moves on one valid/ready stream per pair, with one output register stage. An input is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the stage is empty or the downstream side takes the held word in the same cycle. A held word and its valid stay unchanged while `out_ready` is low.

Top module: `stereo_mute_ctrl`

## Requirements
- R1: Both registers reset to 0. A read at address 0 returns the mute bits in [3:0] and the lock flags in [11:8]. A read at address 1 returns ramp-disable in bit 0. Every other bit reads 0. A write updates only the mute bits (address 0) or the ramp-disable bit (address 1). Writes to the lock flags and to reserved bits are discarded.
- R2: A pair's lock flag is 0 after reset. It becomes 1 in the cycle after the pair's clock-enable is seen high. While the flag is 1, a lock-achieved indication makes it 0 in the next cycle and marks the pair locked until reset, whatever the clock-enable and lock-achieved inputs do afterwards. A lock-achieved indication before the clock is enabled is ignored.
- R3: A pair that has not reached lock targets silence regardless of its mute bit.
- R4: With ramp-disable at 0, a locked pair targets silence when its mute bit is 1 and full scale when it is 0. The 16-bit gain, where full scale is 32768, moves toward the target by 32 per accepted sample, saturating at 0 and 32768. A reversal mid-fade continues from the current gain.
- R5: With ramp-disable at 1, the gain jumps to its target in the next cycle, and mute bits are ignored, so only an unlocked pair is silenced.
- R6: Pair n's stream word is 48 bits, with channel 2n in bits [23:0] and channel 2n+1 in bits [47:24]. Each is a signed sample. The output sample equals (sample × gain) shifted right arithmetically by 15, keeping the low 24 bits, using the gain in effect when the sample is accepted.
- R7: `out_valid` rises the cycle after an accepted input. `in_ready` = !`out_valid` || `out_ready`. A held word stays stable while `out_ready` is low.
- R8: A pair's `settled` output is 1 exactly when its gain equals its current target: 0 when targeting silence, 32768 when targeting full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 mute/lock, 1 ramp-disable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| clk_en | input | 4 | Per-pair converter clock enabled |
| lock_ok | input | 4 | Per-pair converter lock achieved |
| in_valid | input | 4 | Per-pair input sample valid |
| in_ready | output | 4 | Per-pair input ready |
| in_data | input | 192 | Pair n in bits [48n+47:48n] |
| out_valid | output | 4 | Per-pair output valid |
| out_ready | input | 4 | Per-pair downstream ready |
| out_data | output | 192 | Scaled samples, same layout as `in_data` |
| settled | output | 4 | Per-pair gain at its target endpoint |

## Verification
The bench targets reversals in the middle of a fade and checks that the gain continues from where it was. A design that restarted from an endpoint would produce a jump in the scaled samples. It also checks that a lock flag stays cleared after clock-enable and lock-achieved both drop; a non-sticky flag would re-mute a pair that had already locked. Writes of all-ones probe the reserved and read-only bits, and a leaky mask shows up in the read value. Long stalls on `out_ready` check that a word is held and that the ramp does not step without an accepted sample. With ramp-disable set and mute bits high, a design that still honoured the mute bits would silence a locked pair.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_WAIT = 2'd1,
    LK_DONE = 2'd2
  } lock_state_e;
endpackage

// File: rtl/smc_regs.sv
module smc_regs #(
  parameter int NPAIR  = 4,
  parameter int DATA_W = 16,
  parameter int LOCK_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NPAIR-1:0]  lock_bits,
  output logic [DATA_W-1:0] rdata,
  output logic [NPAIR-1:0]  mute,
  output logic              rdis
);
  logic unused_wbits;
  assign unused_wbits = ^wdata[DATA_W-1:NPAIR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mute <= '0;
      rdis <= 1'b0;
    end else if (wr) begin
      if (addr == 1'b0) mute <= wdata[NPAIR-1:0];
      else              rdis <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == 1'b0) begin
      rdata[NPAIR-1:0]         = mute;
      rdata[LOCK_LSB +: NPAIR] = lock_bits;
    end else begin
      rdata[0] = rdis;
    end
  end

  // R1: mute bits change only through a write at address 0
  a_r1_mute_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 1'b0) |=> $stable(mute));
  // R1: ramp-disable changes only through a write at address 1
  a_r1_rdis_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == 1'b1) |=> $stable(rdis));
endmodule

// File: rtl/smc_lock_trk.sv
module smc_lock_trk
  import smc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic lock_ok,
  output logic lock_bit,
  output logic locked
);
  lock_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= LK_IDLE;
    end else begin
      unique case (state)
        LK_IDLE: if (clk_en)  state <= LK_WAIT;
        LK_WAIT: if (lock_ok) state <= LK_DONE;
        default: state <= LK_DONE;
      endcase
    end
  end

  assign lock_bit = (state == LK_WAIT);
  assign locked   = (state == LK_DONE);

  // R2: once locked, stays locked until reset
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R2: lock is only reached from the waiting state
  a_r2_via_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(state) == LK_WAIT);
endmodule

// File: rtl/smc_gain_ramp.sv
module smc_gain_ramp #(
  parameter int GAIN_W    = 16,
  parameter int RAMP_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_req,
  input  logic              abrupt,
  input  logic              adv,
  output logic [GAIN_W-1:0] gain,
  output logic              settled
);
  localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1) << (GAIN_W - 1);
  localparam logic [GAIN_W-1:0] STEP = FULL >> RAMP_LOG2;

  logic [GAIN_W-1:0] gain_dn;
  logic [GAIN_W-1:0] gain_up;

  always_comb begin
    gain_dn = (gain > STEP) ? (gain - STEP) : '0;
    gain_up = (gain < (FULL - STEP)) ? (gain + STEP) : FULL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain <= '0;
    end else if (abrupt) begin
      gain <= mute_req ? '0 : FULL;
    end else if (adv) begin
      gain <= mute_req ? gain_dn : gain_up;
    end
  end

  assign settled = mute_req ? (gain == '0) : (gain == FULL);

  // R4: gain never exceeds full scale
  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= FULL);
  // R4: no step without an accepted sample while ramping
  a_r4_no_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !abrupt && !adv |=> $stable(gain));
  // R4: fading in never lowers the gain
  a_r4_up_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !abrupt && adv && !mute_req |=> gain >= $past(gain));
  // R5: abrupt mode lands on an endpoint
  a_r5_endpoint: assert property (@(posedge clk) disable iff (!rst_n)
    abrupt |=> (gain == '0) || (gain == FULL));
endmodule

// File: rtl/smc_gain_stage.sv
module smc_gain_stage #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*SAMPLE_W-1:0] in_data,
  input  logic [GAIN_W-1:0]     gain,
  output logic                  accept,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*SAMPLE_W-1:0] out_data
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;

  logic [2*SAMPLE_W-1:0] scaled;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [SAMPLE_W-1:0] smp;
    logic [PW-1:0]       a_ext;
    logic [PW-1:0]       b_ext;
    logic [PW-1:0]       prod;
    logic                unused_prod;
    assign smp   = in_data[c*SAMPLE_W +: SAMPLE_W];
    assign a_ext = {{(PW-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
    assign b_ext = {{(PW-GAIN_W){1'b0}}, gain};
    assign prod  = a_ext * b_ext;
    assign scaled[c*SAMPLE_W +: SAMPLE_W] = prod[GAIN_W-1 +: SAMPLE_W];
    assign unused_prod = ^{prod[PW-1:GAIN_W-1+SAMPLE_W], prod[GAIN_W-2:0]};
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= scaled;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: a stalled word is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  // R7: an accepted input always yields a valid output next cycle
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: rtl/stereo_mute_ctrl.sv
module stereo_mute_ctrl #(
  parameter int NPAIR     = 4,
  parameter int SAMPLE_W  = 24,
  parameter int GAIN_W    = 16,
  parameter int RAMP_LOG2 = 10,
  parameter int REG_W     = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_addr,
  input  logic [REG_W-1:0]            bus_wdata,
  output logic [REG_W-1:0]            bus_rdata,
  input  logic [NPAIR-1:0]            clk_en,
  input  logic [NPAIR-1:0]            lock_ok,
  input  logic [NPAIR-1:0]            in_valid,
  output logic [NPAIR-1:0]            in_ready,
  input  logic [NPAIR*2*SAMPLE_W-1:0] in_data,
  output logic [NPAIR-1:0]            out_valid,
  input  logic [NPAIR-1:0]            out_ready,
  output logic [NPAIR*2*SAMPLE_W-1:0] out_data,
  output logic [NPAIR-1:0]            settled
);
  localparam int WORD_W = 2 * SAMPLE_W;

  logic [NPAIR-1:0] lock_bits;
  logic [NPAIR-1:0] locked;
  logic [NPAIR-1:0] mute;
  logic             rdis;
  logic [NPAIR-1:0] mute_req;
  logic [NPAIR-1:0] accept;

  smc_regs #(.NPAIR(NPAIR), .DATA_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .lock_bits(lock_bits), .rdata(bus_rdata),
    .mute(mute), .rdis(rdis)
  );

  for (genvar n = 0; n < NPAIR; n++) begin : g_pair
    logic [GAIN_W-1:0] gain;

    smc_lock_trk u_lock (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en[n]), .lock_ok(lock_ok[n]),
      .lock_bit(lock_bits[n]), .locked(locked[n])
    );

    assign mute_req[n] = !locked[n] || (!rdis && mute[n]);

    smc_gain_ramp #(.GAIN_W(GAIN_W), .RAMP_LOG2(RAMP_LOG2)) u_ramp (
      .clk(clk), .rst_n(rst_n), .mute_req(mute_req[n]), .abrupt(rdis),
      .adv(accept[n]), .gain(gain), .settled(settled[n])
    );

    smc_gain_stage #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid[n]), .in_ready(in_ready[n]),
      .in_data(in_data[n*WORD_W +: WORD_W]), .gain(gain), .accept(accept[n]),
      .out_valid(out_valid[n]), .out_ready(out_ready[n]),
      .out_data(out_data[n*WORD_W +: WORD_W])
    );

    // R3: an unlocked pair is never settled at full scale
    a_r3_unlocked_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !locked[n] && settled[n] |-> gain == '0);
  end
endmodule

// File: tb/stereo_mute_ctrl_bench.sv
module stereo_mute_ctrl_bench;
  localparam int NP = 4;
  localparam int SW = 24;
  localparam int WW = 48;
  localparam logic [15:0] FULL = 16'd32768;
  localparam logic [15:0] STEP = 16'd32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [NP-1:0] clk_en = '0, lock_ok = '0, in_valid = '0, out_ready = '0;
  logic [NP-1:0] in_ready, out_valid, settled;
  logic [NP*WW-1:0] in_data = '0;
  logic [NP*WW-1:0] out_data;

  always #2.5 clk = ~clk;

  stereo_mute_ctrl u_stereo_mute_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en),
    .lock_ok(lock_ok), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .settled(settled)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference state: 0 idle, 1 waiting, 2 locked
  int          m_st [NP];
  logic [15:0] m_g  [NP];
  logic        m_ov [NP];
  logic [WW-1:0] m_od [NP];
  logic [NP-1:0] m_mute;
  logic          m_rdis;

  function automatic logic [SW-1:0] scale(logic [SW-1:0] s, logic [15:0] g);
    longint p;
    p = longint'($signed(s)) * longint'(g);
    p = p >>> 15;
    return p[SW-1:0];
  endfunction

  function automatic logic m_force(int n);
    return (m_st[n] != 2) || (!m_rdis && m_mute[n]);
  endfunction

  function automatic logic m_rdy(int n);
    return !m_ov[n] || out_ready[n];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int n = 0; n < NP; n++) begin
        m_st[n] <= 0; m_g[n] <= '0; m_ov[n] <= 1'b0; m_od[n] <= '0;
      end
      m_mute <= '0; m_rdis <= 1'b0;
    end else begin
      for (int n = 0; n < NP; n++) begin
        logic acc;
        logic [WW-1:0] w;
        acc = in_valid[n] && m_rdy(n);
        w = in_data[n*WW +: WW];
        if (m_st[n] == 0 && clk_en[n]) m_st[n] <= 1;
        else if (m_st[n] == 1 && lock_ok[n]) m_st[n] <= 2;
        if (m_rdis) m_g[n] <= m_force(n) ? 16'd0 : FULL;
        else if (acc) begin
          if (m_force(n)) m_g[n] <= (m_g[n] > STEP) ? m_g[n] - STEP : 16'd0;
          else m_g[n] <= (m_g[n] < FULL - STEP) ? m_g[n] + STEP : FULL;
        end
        if (acc) begin
          m_ov[n] <= 1'b1;
          m_od[n] <= {scale(w[WW-1:SW], m_g[n]), scale(w[SW-1:0], m_g[n])};
        end else if (out_ready[n]) m_ov[n] <= 1'b0;
      end
      if (bus_wr) begin
        if (!bus_addr) m_mute <= bus_wdata[NP-1:0];
        else m_rdis <= bus_wdata[0];
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic check_all();
    logic [NP-1:0] lk;
    logic [15:0] er;
    for (int n = 0; n < NP; n++) lk[n] = (m_st[n] == 1);
    er = bus_addr ? {15'd0, m_rdis} : {4'd0, lk, 4'd0, m_mute};
    chk("R1 read data", 64'(bus_rdata), 64'(er));
    if (!bus_addr) chk("R2 lock flags", 64'(bus_rdata[11:8]), 64'(lk));
    for (int n = 0; n < NP; n++) begin
      string rg;
      rg = m_rdis ? "R6/R5 data" : (m_st[n] != 2 ? "R6/R3 data" : "R6/R4 data");
      chk("R7 out_valid", 64'(out_valid[n]), 64'(m_ov[n]));
      chk("R7 in_ready", 64'(in_ready[n]), 64'(m_rdy(n)));
      if (m_ov[n]) chk(rg, 64'(out_data[n*WW +: WW]), 64'(m_od[n]));
      chk("R8 settled", 64'(settled[n]),
          64'(m_force(n) ? (m_g[n] == 0) : (m_g[n] == FULL)));
    end
  endtask

  task automatic step(int vpct, int rpct, int wr_div);
    @(negedge clk);
    check_all();
    bus_wr = (wr_div > 0) && ($urandom % wr_div == 0);
    bus_addr = $urandom % 2;
    bus_wdata = 16'($urandom);
    for (int n = 0; n < NP; n++) begin
      in_valid[n] = ($urandom % 100) < vpct;
      out_ready[n] = ($urandom % 100) < rpct;
      in_data[n*WW +: WW] = {16'($urandom), 32'($urandom)};
    end
  endtask

  task automatic write_reg(logic a, logic [15:0] d);
    @(negedge clk);
    check_all();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    check_all();
    bus_wr = 1'b0;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 R2 R8 reset state
    chk("R1 reset read", 64'(bus_rdata), 64'd0);
    chk("R7 reset valid", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset settled", 64'(settled), 64'hF);
    // R1 reserved and read-only bits discarded
    write_reg(1'b0, 16'hFFFF);
    bus_addr = 1'b0; @(negedge clk);
    chk("R1 mask addr0", 64'(bus_rdata), 64'h000F);
    write_reg(1'b1, 16'hFFFF);
    bus_addr = 1'b1; @(negedge clk);
    chk("R1 mask addr1", 64'(bus_rdata), 64'h0001);
    write_reg(1'b1, 16'h0000);
    write_reg(1'b0, 16'h0000);
    // R2 lock_ok before clock enable is ignored
    lock_ok = 4'hF;
    repeat (4) step(50, 50, 0);
    lock_ok = 4'h0;
    clk_en = 4'hF;
    repeat (3) step(50, 50, 0);
    // R2 all flags set, pairs 0 and 1 lock
    bus_addr = 1'b0; @(negedge clk);
    chk("R2 flags set", 64'(bus_rdata[11:8]), 64'hF);
    lock_ok = 4'h3;
    @(negedge clk); lock_ok = 4'h0;
    bus_addr = 1'b0; @(negedge clk);
    chk("R2 flags cleared", 64'(bus_rdata[11:8]), 64'hC);
    // random mix, pairs 2,3 still unlocked (R3)
    for (int i = 0; i < 3000; i++) step(80, 75, 250);
    // R5 ramp disable with mutes set: locked pairs go full scale
    write_reg(1'b0, 16'h000F);
    write_reg(1'b1, 16'h0001);
    repeat (20) step(90, 90, 0);
    // lock remaining, then drop all converter inputs (R2 sticky)
    lock_ok = 4'hC; @(negedge clk);
    lock_ok = 4'h0; clk_en = 4'h0;
    bus_addr = 1'b0; @(negedge clk);
    chk("R2 sticky", 64'(bus_rdata[11:8]), 64'h0);
    write_reg(1'b1, 16'h0000);
    // R4 full ramp up, then reversal midway
    write_reg(1'b0, 16'h0000);
    for (int i = 0; i < 1100; i++) step(100, 100, 0);
    chk("R8 full settled", 64'(settled), 64'hF);
    write_reg(1'b0, 16'h0005);
    for (int i = 0; i < 400; i++) step(100, 100, 0);
    write_reg(1'b0, 16'h0000);
    for (int i = 0; i < 200; i++) step(100, 100, 0);
    // long stalls (R7)
    for (int i = 0; i < 500; i++) step(90, 10, 0);
    // random tail
    for (int i = 0; i < 4000; i++) step(75, 70, 300);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule